// File: doc/BRIEF.md
# Segment Selector Register File with Default Segment Choice

This block holds the six 16-bit segment selectors of a segmented-address processor core. It picks the one that applies to each memory access. The surrounding pipeline supplies two things: the class of the access (instruction fetch, stack push/pop, data reference through the BP base register, string source, string destination, or general data) and an optional override code taken from an instruction prefix. The block combines the class and the override under fixed rules and returns the index of the chosen register together with its selector value. Both outputs come from combinational logic in the same cycle.

The same block also takes register writes. A write takes effect on the next rising clock edge. While the core runs in protected mode, ordinary writes to the code-segment register are refused. The other five registers stay writable in either mode. Decoding instructions into access classes, loading descriptors and forming addresses all happen outside this block.

Register index encoding, used on `sel_idx` and `wr_idx`: 0 = CS, 1 = DS, 2 = SS, 3 = ES, 4 = FS, 5 = GS. Access class encoding on `acc_class`: 0 = fetch, 1 = stack push/pop, 2 = BP-based data, 3 = string source, 4 = string destination, 5 = general data. Codes 6 and 7 are treated as general data. Override encoding on `ovr_code`: 0 = none, and 1 to 6 select CS, DS, SS, ES, FS, GS in that order. Code 7 means none.

Top module: `segsel_unit`

## Requirements
- R1: After a synchronous active-low reset, DS, SS, ES, FS and GS read 0 and CS reads the parameter `CS_RESET`.
- R2: An access of class 0 (fetch) selects CS (index 0) whatever `ovr_code` holds.
- R3: An access of class 1 (stack push/pop) selects SS (index 2) and ignores `ovr_code`.
- R4: An access of class 2 (BP-based data) selects SS when no override is given, and otherwise selects the register named by the override.
- R5: An access of class 4 (string destination) selects ES (index 3) even when an override code 1 to 6 is present.
- R6: An access of class 3 (string source) selects DS when no override is given, and otherwise selects the register named by the override.
- R7: An access of class 5, 6 or 7 (general data) selects DS when no override is given, and otherwise selects the register named by the override.
- R8: Override codes 1 to 6 map to indices 0 to 5, respectively. Codes 0 and 7 count as no override.
- R9: FS (index 4) and GS (index 5) are selected only when `ovr_code` is 5 or 6, respectively.
- R10: `sel_value` always equals the current content of the register named by `sel_idx`. A write with `wr_en`=1 and `wr_idx` 0 to 5 is visible from the cycle after the clock edge. A write with `wr_idx` 6 or 7 changes no register.
- R11: With `prot_mode`=1, a write to CS leaves CS unchanged. Writes to the other five registers take effect in both modes, and writes to CS take effect when `prot_mode`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_class | input | 3 | Access class of the current memory access |
| ovr_code | input | 3 | Prefix override code, 0 or 7 for none |
| prot_mode | input | 1 | 1 while the core runs in protected mode |
| wr_en | input | 1 | Register write request |
| wr_idx | input | 3 | Index of the register to write |
| wr_data | input | SEL_W | Selector value to write |
| sel_idx | output | 3 | Index of the register chosen for this access |
| sel_value | output | SEL_W | Selector held in the chosen register |

## Verification
The selection path is combinational, so a wrong default or a mishandled override shows on `sel_idx` in the same cycle the class and code are applied. A corrupted register shows on `sel_value` the first time that register is selected after the bad write. A refused write to CS that wrongly lands, or a write to an out-of-range index that hits a register, stays hidden until the affected register is read through a fetch or an override. For that reason the bench reads all six registers back after every such write.

// File: rtl/segsel_pkg.sv
// Shared encodings for the segment selector block.
// Assumes: six segment registers, 3-bit access class and override codes.
package segsel_pkg;
    localparam int NSEG = 6;
    localparam int IDX_W = 3;

    localparam logic [IDX_W-1:0] IDX_CS = 3'd0;
    localparam logic [IDX_W-1:0] IDX_DS = 3'd1;
    localparam logic [IDX_W-1:0] IDX_SS = 3'd2;
    localparam logic [IDX_W-1:0] IDX_ES = 3'd3;
    localparam logic [IDX_W-1:0] IDX_FS = 3'd4;
    localparam logic [IDX_W-1:0] IDX_GS = 3'd5;

    localparam logic [2:0] CLS_FETCH   = 3'd0;
    localparam logic [2:0] CLS_STACK   = 3'd1;
    localparam logic [2:0] CLS_BPREF   = 3'd2;
    localparam logic [2:0] CLS_STR_SRC = 3'd3;
    localparam logic [2:0] CLS_STR_DST = 3'd4;
    localparam logic [2:0] CLS_DATA    = 3'd5;
endpackage

// File: rtl/segsel_default.sv
// Chooses the segment register index for one access from its class and
// the prefix override code. Purely combinational.
// Assumes: override codes 1..6 name indices 0..5; 0 and 7 mean none.
module segsel_default
    import segsel_pkg::*;
(
    input  logic [2:0]       acc_class,
    input  logic [2:0]       ovr_code,
    output logic [IDX_W-1:0] pick_idx
);
    logic             ovr_valid;
    logic [IDX_W-1:0] ovr_idx;

    // Decode the override prefix into a valid flag and a register index.
    always_comb begin
        ovr_valid = (ovr_code != 3'd0) && (ovr_code != 3'd7);
        ovr_idx   = ovr_code - 3'd1;
    end

    // Apply the per-class default and the override rules.
    always_comb begin
        case (acc_class)
            CLS_FETCH:   pick_idx = IDX_CS;
            CLS_STACK:   pick_idx = IDX_SS;
            CLS_STR_DST: pick_idx = IDX_ES;
            CLS_BPREF:   pick_idx = ovr_valid ? ovr_idx : IDX_SS;
            default:     pick_idx = ovr_valid ? ovr_idx : IDX_DS;
        endcase
    end
endmodule

// File: rtl/segsel_regfile.sv
// Six selector registers with a write port and a mode-dependent guard on CS.
// Assumes: synchronous active-low reset; wr_idx above 5 addresses nothing.
module segsel_regfile
    import segsel_pkg::*;
#(
    parameter int              SEL_W    = 16,
    parameter logic [SEL_W-1:0] CS_RESET = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       prot_mode,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [SEL_W-1:0]           wr_data,
    output logic [NSEG-1:0][SEL_W-1:0] seg_q
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        localparam logic [SEL_W-1:0] RST_VAL = (g == 0) ? CS_RESET : '0;
        logic hit;
        // Write strobe for this register, refusing CS while protected.
        always_comb begin
            hit = wr_en && (wr_idx == IDX_W'(g));
            if (g == 0) hit = hit && !prot_mode;
        end
        // Hold or load this selector.
        always_ff @(posedge clk) begin
            if (!rst_n)   seg_q[g] <= RST_VAL;
            else if (hit) seg_q[g] <= wr_data;
        end
    end
endmodule

// File: rtl/segsel_readmux.sv
// Returns the selector held in the register named by an index.
// Assumes: index values above 5 never arrive; they return 0.
module segsel_readmux
    import segsel_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  logic [NSEG-1:0][SEL_W-1:0] seg_q,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [SEL_W-1:0]           rd_value
);
    // Select one register by index.
    always_comb begin
        rd_value = '0;
        for (int i = 0; i < NSEG; i++)
            if (rd_idx == IDX_W'(i)) rd_value = seg_q[i];
    end
endmodule

// File: rtl/segsel_unit.sv
// Segment register file with per-access default segment selection.
// Assumes: class and override are valid in the cycle they are applied;
// the selection outputs are combinational, and writes land at the next edge.
module segsel_unit
    import segsel_pkg::*;
#(
    parameter int               SEL_W    = 16,
    parameter logic [SEL_W-1:0] CS_RESET = 16'hF000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       acc_class,
    input  logic [2:0]       ovr_code,
    input  logic             prot_mode,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [SEL_W-1:0] wr_data,
    output logic [2:0]       sel_idx,
    output logic [SEL_W-1:0] sel_value
);
    logic [NSEG-1:0][SEL_W-1:0] seg_q;

    segsel_default u_default (
        .acc_class (acc_class),
        .ovr_code  (ovr_code),
        .pick_idx  (sel_idx)
    );

    segsel_regfile #(.SEL_W(SEL_W), .CS_RESET(CS_RESET)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_mode (prot_mode),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .seg_q     (seg_q)
    );

    segsel_readmux #(.SEL_W(SEL_W)) u_mux (
        .seg_q    (seg_q),
        .rd_idx   (sel_idx),
        .rd_value (sel_value)
    );
endmodule

// File: rtl/segsel_unit_chk.sv
// Property checker for segsel_unit, attached by bind.
// Assumes: synchronous active-low reset.
module segsel_unit_chk
    import segsel_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [2:0]                 acc_class,
    input logic [2:0]                 ovr_code,
    input logic                       prot_mode,
    input logic                       wr_en,
    input logic [2:0]                 wr_idx,
    input logic [SEL_W-1:0]           wr_data,
    input logic [2:0]                 sel_idx,
    input logic [SEL_W-1:0]           sel_value,
    input logic [NSEG-1:0][SEL_W-1:0] seg_q
);
    p_fetch_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == CLS_FETCH) |-> (sel_idx == IDX_CS));

    p_dst_es_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_class == CLS_STR_DST) |-> (sel_idx == IDX_ES));

    p_fsgs_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_idx == IDX_FS || sel_idx == IDX_GS) |-> (ovr_code == 3'd5 || ovr_code == 3'd6));

    p_cs_guard_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_mode && wr_en && wr_idx == IDX_CS) |=> $stable(seg_q[0]));

    p_ds_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_DS) |=> (seg_q[1] == $past(wr_data)));

    p_bad_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx > IDX_GS) |=> $stable(seg_q));
endmodule

bind segsel_unit segsel_unit_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/segsel_unit_tb.sv
module segsel_unit_tb;
    localparam int          SEL_W  = 16;
    localparam logic [15:0] CS_RST = 16'hF000;

    logic clk = 0, rst_n = 0;
    logic [2:0] acc_class = 0, ovr_code = 0, wr_idx = 0;
    logic prot_mode = 0, wr_en = 0;
    logic [15:0] wr_data = 0;
    logic [2:0] sel_idx;
    logic [15:0] sel_value;
    logic [15:0] model [6];
    int errors = 0, checks = 0;

    always #5 clk = ~clk;

    segsel_unit #(.SEL_W(SEL_W), .CS_RESET(CS_RST)) u_dut (.*);

    // {class, override, expected index}
    localparam logic [8:0] VEC [23] = '{
        {3'd0,3'd0,3'd0}, {3'd0,3'd5,3'd0}, {3'd0,3'd2,3'd0},
        {3'd1,3'd0,3'd2}, {3'd1,3'd4,3'd2}, {3'd1,3'd6,3'd2},
        {3'd2,3'd0,3'd2}, {3'd2,3'd2,3'd1}, {3'd2,3'd5,3'd4},
        {3'd3,3'd0,3'd1}, {3'd3,3'd4,3'd3}, {3'd3,3'd6,3'd5},
        {3'd4,3'd0,3'd3}, {3'd4,3'd1,3'd3}, {3'd4,3'd6,3'd3},
        {3'd5,3'd0,3'd1}, {3'd5,3'd1,3'd0}, {3'd5,3'd3,3'd2},
        {3'd5,3'd7,3'd1}, {3'd6,3'd0,3'd1}, {3'd7,3'd5,3'd4},
        {3'd5,3'd5,3'd4}, {3'd5,3'd6,3'd5}};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [15:0] d, input logic pm);
        @(negedge clk);
        wr_en = 1; wr_idx = idx; wr_data = d; prot_mode = pm;
        if (idx <= 3'd5 && !(pm && idx == 3'd0)) model[idx] = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Read every register through override codes on general data (R8, R10).
    task automatic read_all(input string req);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            acc_class = 3'd5; ovr_code = 3'(i + 1);
            #1;
            check(req, {13'd0, sel_idx}, 16'(i));
            check(req, sel_value, model[i]);
        end
    endtask

    initial begin
        #200000;
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) model[i] = 16'h0;
        model[0] = CS_RST;
        repeat (3) @(negedge clk);
        rst_n = 1;
        read_all("R1 reset values");

        for (int i = 0; i < 6; i++) wr(3'(i), 16'h1000 + 16'(i) * 16'h0111, 1'b0);
        read_all("R10 R11 real-mode writes");

        // Table walk over class/override combinations (R2..R9).
        for (int v = 0; v < 23; v++) begin
            @(negedge clk);
            acc_class = VEC[v][8:6]; ovr_code = VEC[v][5:3];
            #1;
            check("R2-7 table select (R2 R3 R4 R5 R6 R7 R8 R9)", {13'd0, sel_idx}, {13'd0, VEC[v][2:0]});
            check("R10 table value", sel_value, model[VEC[v][2:0]]);
        end

        // R11: protected mode refuses CS, accepts the others.
        wr(3'd0, 16'hDEAD, 1'b1);
        wr(3'd1, 16'hBEEF, 1'b1);
        wr(3'd5, 16'h5A5A, 1'b1);
        read_all("R11 protected writes");
        @(negedge clk); acc_class = 3'd0; ovr_code = 3'd0; #1;
        check("R11 fetch sees old CS", sel_value, 16'h1000);

        // R10: out-of-range indices touch nothing.
        wr(3'd6, 16'h7777, 1'b0);
        wr(3'd7, 16'h8888, 1'b0);
        read_all("R10 bad index ignored");

        // R11: CS writable again in real mode.
        wr(3'd0, 16'h2468, 1'b0);
        @(negedge clk); acc_class = 3'd0; ovr_code = 3'd4; #1;
        check("R11 CS real-mode write", sel_value, 16'h2468);
        check("R2 fetch ignores override", {13'd0, sel_idx}, 16'd0);

        // R1: second reset restores defaults.
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 6; i++) model[i] = 16'h0;
        model[0] = CS_RST;
        read_all("R1 second reset");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule